// File: doc/BRIEF.md
# Cumulative-Boundary Memory Rank Decoder

This block turns a main-memory physical address into a rank index and a rank-relative bank, row and column. Eight programmable limits describe the memory map. Each limit is the cumulative upper edge of one rank, counted in 64 MiB units. The decoder compares the address against every limit at once. It selects the rank whose window holds the address, then subtracts that window's lower edge to get an offset inside the rank. The offset is split into column, bank and row fields. The column width of each rank comes from its own 2-bit organization code.

The decode is pipelined over two stages. The first stage compares and priority-selects. It captures the address, the lower edge and the organization code of the chosen rank. The second stage subtracts and splits the offset. The limits and codes are sampled in the cycle that a request is presented. They may therefore change between requests without disturbing requests already in the pipeline. An address at or above the highest limit is reported as a miss.

Top module: `rankdec_top`

## Requirements
- R1: While reset is asserted and after it is released, with no request presented, `out_valid`, `out_miss`, `out_rank`, `out_bank`, `out_row` and `out_col` are all zero.
- R2: For a valid request, let the unit number be `in_addr[31:26]`. Limit k is `bound_flat[6k+5:6k]`, and the lower edge of rank 0 is zero. The block reports the lowest rank k for which the unit number is below limit k. With non-decreasing limits, this is the rank k for which the unit number is at least limit k-1 and below limit k.
- R3: A rank whose limit equals the limit of the rank below it (an empty rank) is never reported.
- R4: When the unit number is at or above limit 7, `out_miss` is 1 and `out_rank`, `out_bank`, `out_row` and `out_col` are all zero. Otherwise `out_miss` is 0.
- R5: The offset is `in_addr` minus the lower edge of the selected rank shifted left by 26.
- R6: The column width of rank k is 9 plus the organization code `org_flat[2k+1:2k]`. That gives 9, 10, 11 or 12 bits. `out_col` holds the low column-width bits of the offset, zero-extended to 12 bits.
- R7: `out_bank` holds the 3 offset bits directly above the column bits.
- R8: `out_row` holds the offset bits above the bank bits, zero-extended to 20 bits.
- R9: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high. The result fields in that cycle belong to that request.
- R10: A new request is accepted in every cycle. Back-to-back requests and idle gaps between them each produce their own result in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 32 | Physical address of the request |
| bound_flat | input | 48 | Eight 6-bit cumulative rank limits in 64 MiB units, rank 0 in the low bits |
| org_flat | input | 16 | Eight 2-bit organization codes, rank 0 in the low bits |
| out_valid | output | 1 | Result valid |
| out_miss | output | 1 | Address lies above every rank |
| out_rank | output | 3 | Selected rank index |
| out_bank | output | 3 | Bank field of the offset |
| out_row | output | 20 | Row field of the offset |
| out_col | output | 12 | Column field of the offset |

## Verification
The hardest cases to reach are maps with empty ranks, including several empty ranks in a row and a map whose first limit is zero. In these maps the unit number sits exactly on a repeated limit. Priority selection then has to skip every empty window and land on the next non-empty rank. The bench builds such maps on purpose, plus an all-zero map, an all-full map and sorted random maps. For each map it sweeps every one of the 64 unit numbers. Each unit number is tried with several low-order offsets that exercise every column width, with idle gaps mixed into a stream that is otherwise back-to-back.

// File: rtl/rankdec_pkg.sv
package rankdec_pkg;
  localparam int ORG_W = 2;
  localparam int NUM_ORGS = 1 << ORG_W;
  typedef logic [ORG_W-1:0] org_t;
endpackage

// File: rtl/rankdec_compare.sv
module rankdec_compare
  import rankdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 26,
  parameter int NUM_RANKS  = 8,
  localparam int BND_W     = ADDR_W - UNIT_SHIFT,
  localparam int RANK_W    = $clog2(NUM_RANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [NUM_RANKS*BND_W-1:0] bound_flat,
  input  logic [NUM_RANKS*ORG_W-1:0] org_flat,
  output logic                       s1_valid,
  output logic                       s1_miss,
  output logic [RANK_W-1:0]          s1_rank,
  output logic [ADDR_W-1:0]          s1_addr,
  output logic [BND_W-1:0]           s1_base,
  output org_t                       s1_org
);

  logic [BND_W-1:0]     lim [NUM_RANKS];
  logic [BND_W-1:0]     lo  [NUM_RANKS];
  org_t                 org_a [NUM_RANKS];
  logic [NUM_RANKS-1:0] under;
  logic [BND_W-1:0]     unit;

  assign unit = in_addr[ADDR_W-1:UNIT_SHIFT];

  // Parallel comparison against every cumulative limit
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    assign lim[g]   = bound_flat[g*BND_W +: BND_W];
    assign org_a[g] = org_flat[g*ORG_W +: ORG_W];
    assign under[g] = (unit < lim[g]);
    if (g == 0) begin : g_first
      assign lo[g] = '0;
    end else begin : g_next
      assign lo[g] = lim[g-1];
    end
  end

  // Next-state: lowest rank whose limit lies above the address
  logic              hit_d;
  logic [RANK_W-1:0] rank_d;
  logic [BND_W-1:0]  base_d;
  org_t              org_d;

  always_comb begin
    hit_d  = 1'b0;
    rank_d = '0;
    base_d = '0;
    org_d  = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (under[i]) begin
        hit_d  = 1'b1;
        rank_d = RANK_W'(i);
        base_d = lo[i];
        org_d  = org_a[i];
      end
    end
  end

  // Registers: valid always advances, payload loads on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_miss  <= 1'b0;
      s1_rank  <= '0;
      s1_addr  <= '0;
      s1_base  <= '0;
      s1_org   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_miss <= !hit_d;
        s1_rank <= rank_d;
        s1_addr <= in_addr;
        s1_base <= base_d;
        s1_org  <= org_d;
      end
    end
  end

  // R2: the chosen rank window contains the address
  a_r2_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit_d) |-> (unit < lim[rank_d]) && (unit >= lo[rank_d]));

  // R4: a miss only when the address clears the top limit
  a_r4_miss_above_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit_d) |-> (unit >= lim[NUM_RANKS-1]));

endmodule

// File: rtl/rankdec_split.sv
module rankdec_split
  import rankdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 26,
  parameter int RANK_W     = 3,
  parameter int COL_MIN    = 9,
  parameter int BANK_W     = 3,
  localparam int BND_W     = ADDR_W - UNIT_SHIFT,
  localparam int COL_W     = COL_MIN + NUM_ORGS - 1,
  localparam int ROW_W     = ADDR_W - COL_MIN - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_miss,
  input  logic [RANK_W-1:0] s1_rank,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [BND_W-1:0]  s1_base,
  input  org_t              s1_org,
  output logic              out_valid,
  output logic              out_miss,
  output logic [RANK_W-1:0] out_rank,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col
);

  logic [ADDR_W-1:0] offset;
  assign offset = s1_addr - {s1_base, {UNIT_SHIFT{1'b0}}};

  // One constant-slice field split per organization code
  logic [COL_W-1:0]  col_v  [NUM_ORGS];
  logic [BANK_W-1:0] bank_v [NUM_ORGS];
  logic [ROW_W-1:0]  row_v  [NUM_ORGS];

  for (genvar g = 0; g < NUM_ORGS; g++) begin : g_org
    localparam int CW = COL_MIN + g;
    assign col_v[g]  = COL_W'(offset[CW-1:0]);
    assign bank_v[g] = offset[CW +: BANK_W];
    assign row_v[g]  = ROW_W'(offset >> (CW + BANK_W));
  end

  logic [RANK_W-1:0] rank_d;
  logic [BANK_W-1:0] bank_d;
  logic [ROW_W-1:0]  row_d;
  logic [COL_W-1:0]  col_d;

  always_comb begin
    if (s1_miss) begin
      rank_d = '0;
      bank_d = '0;
      row_d  = '0;
      col_d  = '0;
    end else begin
      rank_d = s1_rank;
      bank_d = bank_v[s1_org];
      row_d  = row_v[s1_org];
      col_d  = col_v[s1_org];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_rank  <= '0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_miss <= s1_miss;
        out_rank <= rank_d;
        out_bank <= bank_d;
        out_row  <= row_d;
        out_col  <= col_d;
      end
    end
  end

  // R6: the column never uses bits beyond the width chosen by the code
  a_r6_col_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |->
      ((32'(out_col) >> (COL_MIN + 32'($past(s1_org)))) == 32'd0));

endmodule

// File: rtl/rankdec_top.sv
module rankdec_top
  import rankdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 26,
  parameter int NUM_RANKS  = 8,
  parameter int COL_MIN    = 9,
  parameter int BANK_W     = 3,
  localparam int BND_W     = ADDR_W - UNIT_SHIFT,
  localparam int RANK_W    = $clog2(NUM_RANKS),
  localparam int COL_W     = COL_MIN + NUM_ORGS - 1,
  localparam int ROW_W     = ADDR_W - COL_MIN - BANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [NUM_RANKS*BND_W-1:0] bound_flat,
  input  logic [NUM_RANKS*ORG_W-1:0] org_flat,
  output logic                       out_valid,
  output logic                       out_miss,
  output logic [RANK_W-1:0]          out_rank,
  output logic [BANK_W-1:0]          out_bank,
  output logic [ROW_W-1:0]           out_row,
  output logic [COL_W-1:0]           out_col
);

  logic              s1_valid;
  logic              s1_miss;
  logic [RANK_W-1:0] s1_rank;
  logic [ADDR_W-1:0] s1_addr;
  logic [BND_W-1:0]  s1_base;
  org_t              s1_org;

  rankdec_compare #(
    .ADDR_W     (ADDR_W),
    .UNIT_SHIFT (UNIT_SHIFT),
    .NUM_RANKS  (NUM_RANKS)
  ) u_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .bound_flat (bound_flat),
    .org_flat   (org_flat),
    .s1_valid   (s1_valid),
    .s1_miss    (s1_miss),
    .s1_rank    (s1_rank),
    .s1_addr    (s1_addr),
    .s1_base    (s1_base),
    .s1_org     (s1_org)
  );

  rankdec_split #(
    .ADDR_W     (ADDR_W),
    .UNIT_SHIFT (UNIT_SHIFT),
    .RANK_W     (RANK_W),
    .COL_MIN    (COL_MIN),
    .BANK_W     (BANK_W)
  ) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_miss   (s1_miss),
    .s1_rank   (s1_rank),
    .s1_addr   (s1_addr),
    .s1_base   (s1_base),
    .s1_org    (s1_org),
    .out_valid (out_valid),
    .out_miss  (out_miss),
    .out_rank  (out_rank),
    .out_bank  (out_bank),
    .out_row   (out_row),
    .out_col   (out_col)
  );

  // R9: a request yields a result exactly two cycles later
  a_r9_latency_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R9: no result appears without a request two cycles earlier
  a_r9_latency_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R4: a miss drives every selection field to zero
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |->
      (out_rank == '0 && out_bank == '0 && out_row == '0 && out_col == '0));

endmodule

// File: tb/tb_rankdec_top.sv
`timescale 1ns/1ps
module tb_rankdec_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [47:0] bound_flat;
  logic [15:0] org_flat;
  logic        out_valid;
  logic        out_miss;
  logic [2:0]  out_rank;
  logic [2:0]  out_bank;
  logic [19:0] out_row;
  logic [11:0] out_col;

  int checks;
  int errors;
  bit done;

  rankdec_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .bound_flat (bound_flat),
    .org_flat   (org_flat),
    .out_valid  (out_valid),
    .out_miss   (out_miss),
    .out_rank   (out_rank),
    .out_bank   (out_bank),
    .out_row    (out_row),
    .out_col    (out_col)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int lim [8];
  int org [8];

  // Expected results, three slots for a two-stage pipeline
  bit          e_valid [3];
  bit          e_miss  [3];
  int          e_rank  [3];
  bit          e_empty [3];
  logic [31:0] e_bank  [3];
  logic [31:0] e_row   [3];
  logic [31:0] e_col   [3];
  int          slot;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_map();
    for (int i = 0; i < 8; i++) begin
      bound_flat[6*i +: 6] = 6'(lim[i]);
      org_flat[2*i +: 2]   = 2'(org[i]);
    end
  endtask

  // One cycle: check the result due now, then present the next request
  task automatic step(input bit v, input logic [31:0] a);
    int old;
    int k;
    int cw;
    logic [31:0] off;
    @(negedge clk);
    old = (slot + 1) % 3;
    check(out_valid == e_valid[old], "R9 R10 valid", 32'(out_valid), 32'(e_valid[old]));
    if (e_valid[old]) begin
      check(out_miss == e_miss[old], "R4 miss", 32'(out_miss), 32'(e_miss[old]));
      check(32'(out_rank) == 32'(e_rank[old]), "R2 rank", 32'(out_rank), 32'(e_rank[old]));
      if (!e_miss[old])
        check(!e_empty[old], "R3 empty rank chosen", 32'(out_rank), 32'(e_rank[old]));
      check(32'(out_col) == e_col[old], "R6 R5 column", 32'(out_col), e_col[old]);
      check(32'(out_bank) == e_bank[old], "R7 bank", 32'(out_bank), e_bank[old]);
      check(32'(out_row) == e_row[old], "R8 row", 32'(out_row), e_row[old]);
    end
    // Reference model for the new request
    e_valid[slot] = v;
    e_miss[slot]  = 1'b1;
    e_rank[slot]  = 0;
    e_empty[slot] = 1'b0;
    e_bank[slot]  = 0;
    e_row[slot]   = 0;
    e_col[slot]   = 0;
    for (k = 0; k < 8; k++) if (int'(a >> 26) < lim[k]) break;
    if (k < 8) begin
      e_miss[slot]  = 1'b0;
      e_rank[slot]  = k;
      e_empty[slot] = (k > 0) && (lim[k] == lim[k-1]);
      off = a - ((k == 0) ? 32'd0 : (32'(lim[k-1]) << 26));
      cw = 9 + org[k];
      e_col[slot]  = off & ((32'd1 << cw) - 1);
      e_bank[slot] = (off >> cw) & 32'd7;
      e_row[slot]  = off >> (cw + 3);
    end
    in_valid = v;
    in_addr  = a;
    slot = (slot + 1) % 3;
  endtask

  task automatic sweep(input int seed_lo);
    int n;
    logic [31:0] lows [5];
    n = 0;
    lows[0] = 32'h0;
    lows[1] = 32'h03FF_FFFF;
    lows[2] = 32'(seed_lo) & 32'h03FF_FFFF;
    lows[3] = 32'h0155_5555;
    lows[4] = 32'h02AA_AAAA;
    load_map();
    for (int u = 0; u < 64; u++) begin
      for (int p = 0; p < 5; p++) begin
        n++;
        if (n % 7 == 0) step(1'b0, 32'h0);
        step(1'b1, (32'(u) << 26) | lows[p]);
      end
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    slot = 0;
    for (int i = 0; i < 3; i++) e_valid[i] = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_addr = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin lim[i] = 7 * (i + 1); org[i] = i % 4; end
    load_map();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_miss == 1'b0 && out_rank == 0 && out_bank == 0 &&
          out_row == 0 && out_col == 0, "R1 reset outputs", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && out_row == 0 && out_col == 0, "R1 idle after reset",
          32'(out_valid), 32'h0);

    // Even map with varied column widths
    sweep(32'h00AB_CDEF);
    // R3: empty ranks, consecutive empties and a zero first limit
    lim = '{0, 4, 4, 10, 10, 10, 30, 40};
    org = '{3, 2, 1, 0, 3, 2, 1, 0};
    sweep(32'h0012_3456);
    // R4: all-zero map misses everywhere
    lim = '{0, 0, 0, 0, 0, 0, 0, 0};
    sweep(32'h0000_0001);
    // Full map: rank 0 holds all but the top unit
    lim = '{63, 63, 63, 63, 63, 63, 63, 63};
    org = '{2, 0, 0, 0, 0, 0, 0, 0};
    sweep(32'h03FF_FFFE);
    // Sorted random maps
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < 8; i++) begin
        lim[i] = $urandom_range(0, 63);
        org[i] = $urandom_range(0, 3);
      end
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 7 - i; j++)
          if (lim[j] > lim[j+1]) begin
            int t;
            t = lim[j]; lim[j] = lim[j+1]; lim[j+1] = t;
          end
      sweep(int'($urandom));
    end
    step(1'b0, 32'h0);
    step(1'b0, 32'h0);
    step(1'b0, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule